// File: doc/BRIEF.md
# SDRAM Command and Bank State Tracker

This block sits between the request side of a memory controller and the command pins of a four-bank synchronous DRAM. Each cycle it takes at most one request, which names an operation, a bank, a row or column, and a one-bit modifier flag. In the same cycle it answers whether the request is taken, must be retried later, or is illegal in the current bank state. A taken request appears on the registered chip-select, row-strobe, column-strobe, write-enable, bank and address pins one clock later.

The block keeps, for every bank, whether a row is open, whether an automatic close is pending, and a down-counter. That counter enforces the activate-to-column delay, the burst length before an automatic close, and the precharge time before the next activate. A second, shared counter holds off all traffic after a refresh or a mode-register load. Address bit 10 does two jobs. On a read or write it asks for an automatic close at the end of the burst. On a precharge it widens the close to every bank.

The data path, the refresh interval scheduler and the low-power states are handled elsewhere. The front end simply retries any stalled request until it is taken.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: A taken request drives {cs_n, ras_n, cas_n, we_n} on the clock edge that follows. The request op code maps to the pin pattern as follows: 0 activate = 0011, 1 read = 0101, 2 write = 0100, 3 precharge = 0010, 4 auto refresh = 0001, 5 mode load = 0000. Op codes 6 and 7 always get the error answer.
- R2: An activate puts the row on the address pins and the bank on the bank pins. A read or write maps column bits 9:0 to address bits 9:0 and column bit 10 to address bit 11; address bit 10 carries the flag and address bit 12 is 0. A mode load drives the row field onto the address pins and the bank field onto the bank pins. A refresh drives 0 on both.
- R3: An activate to a bank that is open gets the error answer. A read or write to a bank that is idle, or whose automatic close is pending, gets the error answer.
- R4: A read or write to an open bank stalls until T_RCD clocks (default 2) have passed since that bank's activate was taken.
- R5: A read or write with the flag set keeps the bank open for BURST_LEN clocks (default 4) and then closes it. While the close is pending, an activate to that bank stalls. After the close, an activate still stalls for T_RP clocks (default 2).
- R6: A precharge with the flag clear closes only the named bank. With the flag set it closes every bank, whatever the bank field says. An activate to a bank closed this way stalls for T_RP clocks. A precharge that would touch a bank with a pending automatic close stalls.
- R7: A refresh or mode load gets the error answer while any bank is open. It stalls while any bank's precharge time is still running. Once one is taken, every request stalls for T_RFC clocks after a refresh or T_MRD clocks after a mode load.
- R8: In a cycle with no request, the pins show 1111, no answer is raised, and every counter keeps counting.
- R9: A valid request raises exactly one of accept, stall and error. The error answer takes precedence over a stall.
- R10: Reset drives the pins to 1111, closes every bank and clears every counter, so an activate right after reset is taken.
- R11: bank_open bit i is 1 from the edge that takes an activate to bank i until the edge at which that bank closes, including while an automatic close is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is presented this cycle |
| req_op | input | 3 | Operation code (see R1) |
| req_bank | input | BA_W | Target bank |
| req_flag | input | 1 | Auto-close on read/write, all banks on precharge |
| req_row | input | ROW_W | Row for activate, mode value for mode load |
| req_col | input | COL_W | Column for read/write |
| req_accept | output | 1 | Request taken this cycle |
| req_stall | output | 1 | Request legal but timing not yet met |
| req_error | output | 1 | Request illegal in present bank state |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank pins |
| sd_addr | output | ROW_W | Address pins |
| bank_open | output | 2**BA_W | Per-bank open state |

## Verification
The main check walks a back-to-back request sequence and compares the answer, the pins and bank_open every cycle. The sequence mixes legal commands on idle and open banks, which confirm the pin codes and address packing. It also sends each command one clock before its timer expires and then again when the timer expires, which pins each delay to an exact cycle rather than just its order. Requests that are illegal for the bank state show that error and stall are told apart, including a case where both apply. Empty cycles show that timers advance with nothing issued. Separate directed steps cover reset in the middle of an open row, and an unused op code.

// File: rtl/sdram_trk_pkg.sv
// Package: shared op codes, bank states, answer codes and pin patterns
// for the SDRAM command tracker. Assumes a 3-bit request op field.
package sdram_trk_pkg;

    typedef enum logic [2:0] {
        OP_ACT = 3'd0,
        OP_RD  = 3'd1,
        OP_WR  = 3'd2,
        OP_PRE = 3'd3,
        OP_REF = 3'd4,
        OP_MRS = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        BK_IDLE,
        BK_OPEN,
        BK_CLOSING
    } bank_st_e;

    typedef enum logic [1:0] {
        RSP_NONE,
        RSP_ACC,
        RSP_STALL,
        RSP_ERR
    } resp_e;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] PIN_ACT   = 4'b0011;
    localparam logic [3:0] PIN_RD    = 4'b0101;
    localparam logic [3:0] PIN_WR    = 4'b0100;
    localparam logic [3:0] PIN_PRE   = 4'b0010;
    localparam logic [3:0] PIN_REF   = 4'b0001;
    localparam logic [3:0] PIN_MRS   = 4'b0000;
    localparam logic [3:0] PIN_DESEL = 4'b1111;

endpackage

// File: rtl/sdram_bank_fsm.sv
// Module: one bank's state and timer. Holds idle/open/closing and a
// down-counter whose meaning follows the state: activate-to-column delay
// while open, burst length while closing, precharge time while idle.
// Assumes the judge never strobes an operation that is illegal for the state
// and that every timing parameter is at least 1.
module sdram_bank_fsm
    import sdram_trk_pkg::*;
#(
    parameter int T_RCD     = 2,
    parameter int T_RP      = 2,
    parameter int BURST_LEN = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     act_i,
    input  logic     col_i,
    input  logic     ap_i,
    input  logic     pre_i,
    output bank_st_e st_o,
    output logic     rdy_o
);

    localparam int MAX_A = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int MAX_V = (MAX_A > BURST_LEN) ? MAX_A : BURST_LEN;
    localparam int CW    = (MAX_V < 2) ? 1 : $clog2(MAX_V);
    localparam logic [CW-1:0] RCD_LD = CW'(T_RCD - 1);
    localparam logic [CW-1:0] RP_LD  = CW'(T_RP - 1);
    localparam logic [CW-1:0] BL_LD  = CW'(BURST_LEN - 1);

    bank_st_e      st;
    logic [CW-1:0] cnt;

    // State and counter update, highest priority first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= BK_IDLE;
            cnt <= '0;
        end else if (act_i) begin
            st  <= BK_OPEN;
            cnt <= RCD_LD;
        end else if (col_i && ap_i) begin
            st  <= BK_CLOSING;
            cnt <= BL_LD;
        end else if (pre_i && st == BK_OPEN) begin
            st  <= BK_IDLE;
            cnt <= RP_LD;
        end else if (st == BK_CLOSING && cnt == '0) begin
            st  <= BK_IDLE;
            cnt <= RP_LD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign st_o  = st;
    assign rdy_o = (cnt == '0);

endmodule

// File: rtl/sdram_req_judge.sv
// Module: combinational decision on the presented request. Produces one
// answer (accept, stall, error or none) and per-bank strobes for a taken
// request. Assumes bank states and timer-done flags come from the bank FSMs
// and the shared hold-off timer.
module sdram_req_judge
    import sdram_trk_pkg::*;
#(
    parameter int BA_W = 2,
    localparam int NB  = 1 << BA_W
) (
    input  logic            req_valid,
    input  logic [2:0]      req_op,
    input  logic [BA_W-1:0] req_bank,
    input  logic            req_flag,
    input  bank_st_e        bank_st_i [NB],
    input  logic [NB-1:0]   bank_rdy_i,
    input  logic            quiet_done_i,
    output resp_e           resp_o,
    output logic [NB-1:0]   act_o,
    output logic [NB-1:0]   col_o,
    output logic            ap_o,
    output logic [NB-1:0]   pre_o
);

    bank_st_e sel_st;
    logic     sel_rdy, any_used, any_closing, all_rdy;
    logic     err, stl;

    // Summaries across all banks.
    always_comb begin
        any_used    = 1'b0;
        any_closing = 1'b0;
        for (int b = 0; b < NB; b++) begin
            any_used    = any_used | (bank_st_i[b] != BK_IDLE);
            any_closing = any_closing | (bank_st_i[b] == BK_CLOSING);
        end
        all_rdy = &bank_rdy_i;
        sel_st  = bank_st_i[req_bank];
        sel_rdy = bank_rdy_i[req_bank];
    end

    // Legality (error) and timing (stall) per operation.
    always_comb begin
        err = 1'b0;
        stl = 1'b0;
        case (req_op)
            OP_ACT: begin
                err = (sel_st == BK_OPEN);
                stl = (sel_st == BK_CLOSING) || !sel_rdy;
            end
            OP_RD, OP_WR: begin
                err = (sel_st != BK_OPEN);
                stl = !sel_rdy;
            end
            OP_PRE: begin
                stl = req_flag ? any_closing : (sel_st == BK_CLOSING);
            end
            OP_REF, OP_MRS: begin
                err = any_used;
                stl = !all_rdy;
            end
            default: err = 1'b1;
        endcase
        stl = stl | !quiet_done_i;
    end

    // Single answer, error ahead of stall.
    always_comb begin
        if (!req_valid)  resp_o = RSP_NONE;
        else if (err)    resp_o = RSP_ERR;
        else if (stl)    resp_o = RSP_STALL;
        else             resp_o = RSP_ACC;
    end

    // Per-bank strobes for a taken request.
    always_comb begin
        for (int b = 0; b < NB; b++) begin
            act_o[b] = (resp_o == RSP_ACC) && (req_op == OP_ACT) && (req_bank == BA_W'(b));
            col_o[b] = (resp_o == RSP_ACC) && (req_op == OP_RD || req_op == OP_WR)
                       && (req_bank == BA_W'(b));
            pre_o[b] = (resp_o == RSP_ACC) && (req_op == OP_PRE)
                       && (req_flag || req_bank == BA_W'(b));
        end
        ap_o = req_flag;
    end

endmodule

// File: rtl/sdram_pin_driver.sv
// Module: registered command pins. Encodes a taken request onto the strobe,
// bank and address pins one clock later; drives deselect otherwise while
// bank and address hold. Assumes ROW_W > COL_W and that bit AP_BIT of the
// address carries the auto-close / all-banks flag.
module sdram_pin_driver
    import sdram_trk_pkg::*;
#(
    parameter int BA_W   = 2,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 11,
    parameter int AP_BIT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_i,
    input  logic [2:0]       req_op,
    input  logic [BA_W-1:0]  req_bank,
    input  logic             req_flag,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    output logic             sd_cs_n,
    output logic             sd_ras_n,
    output logic             sd_cas_n,
    output logic             sd_we_n,
    output logic [BA_W-1:0]  sd_ba,
    output logic [ROW_W-1:0] sd_addr
);

    logic [ROW_W-1:0] col_addr;
    logic [ROW_W-1:0] pre_addr;
    logic [3:0]       code;

    // Column bits skip over the flag position.
    for (genvar k = 0; k < COL_W; k++) begin : g_col
        if (k < AP_BIT) begin : g_lo
            assign col_addr[k] = req_col[k];
        end else begin : g_hi
            assign col_addr[k+1] = req_col[k];
        end
    end
    assign col_addr[AP_BIT] = req_flag;
    for (genvar k = COL_W + 1; k < ROW_W; k++) begin : g_pad
        assign col_addr[k] = 1'b0;
    end

    assign pre_addr = ROW_W'(req_flag) << AP_BIT;

    // Pin pattern for the presented op.
    always_comb begin
        case (req_op)
            OP_ACT:  code = PIN_ACT;
            OP_RD:   code = PIN_RD;
            OP_WR:   code = PIN_WR;
            OP_PRE:  code = PIN_PRE;
            OP_REF:  code = PIN_REF;
            OP_MRS:  code = PIN_MRS;
            default: code = PIN_DESEL;
        endcase
    end

    // Register the command, bank and address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= PIN_DESEL;
            sd_ba   <= '0;
            sd_addr <= '0;
        end else if (issue_i) begin
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= code;
            case (req_op)
                OP_ACT, OP_MRS: begin
                    sd_ba   <= req_bank;
                    sd_addr <= req_row;
                end
                OP_RD, OP_WR: begin
                    sd_ba   <= req_bank;
                    sd_addr <= col_addr;
                end
                OP_PRE: begin
                    sd_ba   <= req_bank;
                    sd_addr <= pre_addr;
                end
                default: begin
                    sd_ba   <= '0;
                    sd_addr <= '0;
                end
            endcase
        end else begin
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= PIN_DESEL;
        end
    end

endmodule

// File: rtl/sdram_cmd_tracker.sv
// Module: top of the SDRAM command tracker. Instantiates one state FSM per
// bank, the request judge, the pin driver, and a shared hold-off timer for
// refresh and mode load. Assumes the front end retries stalled requests.
module sdram_cmd_tracker
    import sdram_trk_pkg::*;
#(
    parameter int BA_W      = 2,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 11,
    parameter int T_RCD     = 2,
    parameter int T_RP      = 2,
    parameter int BURST_LEN = 4,
    parameter int T_RFC     = 9,
    parameter int T_MRD     = 2,
    localparam int NB       = 1 << BA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_op,
    input  logic [BA_W-1:0]  req_bank,
    input  logic             req_flag,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    output logic             req_accept,
    output logic             req_stall,
    output logic             req_error,
    output logic             sd_cs_n,
    output logic             sd_ras_n,
    output logic             sd_cas_n,
    output logic             sd_we_n,
    output logic [BA_W-1:0]  sd_ba,
    output logic [ROW_W-1:0] sd_addr,
    output logic [NB-1:0]    bank_open
);

    localparam int QMAX = (T_RFC > T_MRD) ? T_RFC : T_MRD;
    localparam int QW   = (QMAX < 2) ? 1 : $clog2(QMAX);
    localparam logic [QW-1:0] RFC_LD = QW'(T_RFC - 1);
    localparam logic [QW-1:0] MRD_LD = QW'(T_MRD - 1);

    bank_st_e      bank_st [NB];
    logic [NB-1:0] bank_rdy, act_s, col_s, pre_s;
    logic          ap_s, issue;
    resp_e         resp;
    logic [QW-1:0] quiet_cnt;

    sdram_req_judge #(.BA_W(BA_W)) u_judge (
        .req_valid    (req_valid),
        .req_op       (req_op),
        .req_bank     (req_bank),
        .req_flag     (req_flag),
        .bank_st_i    (bank_st),
        .bank_rdy_i   (bank_rdy),
        .quiet_done_i (quiet_cnt == '0),
        .resp_o       (resp),
        .act_o        (act_s),
        .col_o        (col_s),
        .ap_o         (ap_s),
        .pre_o        (pre_s)
    );

    for (genvar g = 0; g < NB; g++) begin : g_bank
        sdram_bank_fsm #(
            .T_RCD     (T_RCD),
            .T_RP      (T_RP),
            .BURST_LEN (BURST_LEN)
        ) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .act_i (act_s[g]),
            .col_i (col_s[g]),
            .ap_i  (ap_s),
            .pre_i (pre_s[g]),
            .st_o  (bank_st[g]),
            .rdy_o (bank_rdy[g])
        );
        assign bank_open[g] = (bank_st[g] != BK_IDLE);
    end

    assign issue      = (resp == RSP_ACC);
    assign req_accept = issue;
    assign req_stall  = (resp == RSP_STALL);
    assign req_error  = (resp == RSP_ERR);

    // Shared hold-off after refresh or mode load.
    always_ff @(posedge clk) begin
        if (!rst_n)                           quiet_cnt <= '0;
        else if (issue && req_op == OP_REF)   quiet_cnt <= RFC_LD;
        else if (issue && req_op == OP_MRS)   quiet_cnt <= MRD_LD;
        else if (quiet_cnt != '0)             quiet_cnt <= quiet_cnt - 1'b1;
    end

    sdram_pin_driver #(
        .BA_W  (BA_W),
        .ROW_W (ROW_W),
        .COL_W (COL_W)
    ) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue_i  (issue),
        .req_op   (req_op),
        .req_bank (req_bank),
        .req_flag (req_flag),
        .req_row  (req_row),
        .req_col  (req_col),
        .sd_cs_n  (sd_cs_n),
        .sd_ras_n (sd_ras_n),
        .sd_cas_n (sd_cas_n),
        .sd_we_n  (sd_we_n),
        .sd_ba    (sd_ba),
        .sd_addr  (sd_addr)
    );

endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
// Module: protocol checker bound to the tracker top. Observes ports only.
module sdram_cmd_tracker_chk
    import sdram_trk_pkg::*;
#(
    parameter int BA_W = 2,
    localparam int NB  = 1 << BA_W
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [2:0]      req_op,
    input logic [BA_W-1:0] req_bank,
    input logic            req_flag,
    input logic            req_accept,
    input logic            req_stall,
    input logic            req_error,
    input logic            sd_cs_n,
    input logic [NB-1:0]   bank_open
);

    p_one_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_accept, req_stall, req_error}));

    p_silent_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !(req_accept || req_stall || req_error));

    p_deselect_after_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> sd_cs_n);

    p_select_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_accept |=> !sd_cs_n);

    p_unused_op_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op > 3'd5) |-> req_error);

    p_act_on_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_accept && req_op == OP_ACT) |-> !bank_open[req_bank]);

    p_col_on_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_accept && (req_op == OP_RD || req_op == OP_WR)) |-> bank_open[req_bank]);

    p_ref_all_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_accept && (req_op == OP_REF || req_op == OP_MRS)) |-> (bank_open == '0));

    p_act_opens_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_accept && req_op == OP_ACT) |=> bank_open[$past(req_bank)]);

    p_pre_all_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_accept && req_op == OP_PRE && req_flag) |=> (bank_open == '0));

endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(.BA_W(BA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_bank   (req_bank),
    .req_flag   (req_flag),
    .req_accept (req_accept),
    .req_stall  (req_stall),
    .req_error  (req_error),
    .sd_cs_n    (sd_cs_n),
    .bank_open  (bank_open)
);

// File: tb/sdram_cmd_tracker_tb.sv
module sdram_cmd_tracker_tb;

    localparam int TB_RCD = 2, TB_RP = 2, TB_BL = 4, TB_RFC = 4, TB_MRD = 2;

    localparam logic [2:0] O_ACT = 3'd0, O_RD = 3'd1, O_WR = 3'd2,
                           O_PRE = 3'd3, O_REF = 3'd4, O_MRS = 3'd5;
    localparam logic [1:0] A_ = 2'd0, S_ = 2'd1, E_ = 2'd2, N_ = 2'd3;

    typedef struct packed {
        logic        v;
        logic [2:0]  op;
        logic [1:0]  bk;
        logic        fl;
        logic [12:0] row;
        logic [10:0] col;
        logic [1:0]  rsp;
        logic [3:0]  cmd;
        logic [1:0]  ba;
        logic [12:0] addr;
        logic [3:0]  opn;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VEC [NV] = '{
        '{1'b1, O_MRS, 2'd0, 1'b0, 13'h0032, 11'h000, A_, 4'b0000, 2'd0, 13'h0032, 4'b0000},
        '{1'b1, O_ACT, 2'd0, 1'b0, 13'h1ABC, 11'h000, S_, 4'b1111, 2'd0, 13'h0000, 4'b0000},
        '{1'b1, O_ACT, 2'd0, 1'b0, 13'h1ABC, 11'h000, A_, 4'b0011, 2'd0, 13'h1ABC, 4'b0001},
        '{1'b1, O_RD,  2'd0, 1'b0, 13'h0000, 11'h005, S_, 4'b1111, 2'd0, 13'h0000, 4'b0001},
        '{1'b1, O_RD,  2'd0, 1'b0, 13'h0000, 11'h005, A_, 4'b0101, 2'd0, 13'h0005, 4'b0001},
        '{1'b1, O_ACT, 2'd0, 1'b0, 13'h0123, 11'h000, E_, 4'b1111, 2'd0, 13'h0000, 4'b0001},
        '{1'b1, O_ACT, 2'd1, 1'b0, 13'h0010, 11'h000, A_, 4'b0011, 2'd1, 13'h0010, 4'b0011},
        '{1'b1, O_WR,  2'd1, 1'b1, 13'h0000, 11'h40A, S_, 4'b1111, 2'd0, 13'h0000, 4'b0011},
        '{1'b1, O_WR,  2'd1, 1'b1, 13'h0000, 11'h40A, A_, 4'b0100, 2'd1, 13'h0C0A, 4'b0011},
        '{1'b1, O_RD,  2'd1, 1'b0, 13'h0000, 11'h001, E_, 4'b1111, 2'd0, 13'h0000, 4'b0011},
        '{1'b1, O_ACT, 2'd1, 1'b0, 13'h0020, 11'h000, S_, 4'b1111, 2'd0, 13'h0000, 4'b0011},
        '{1'b1, O_PRE, 2'd2, 1'b0, 13'h0000, 11'h000, A_, 4'b0010, 2'd2, 13'h0000, 4'b0011},
        '{1'b1, O_REF, 2'd0, 1'b0, 13'h0000, 11'h000, E_, 4'b1111, 2'd0, 13'h0000, 4'b0001},
        '{1'b1, O_ACT, 2'd1, 1'b0, 13'h0FFF, 11'h000, S_, 4'b1111, 2'd0, 13'h0000, 4'b0001},
        '{1'b1, O_ACT, 2'd1, 1'b0, 13'h0FFF, 11'h000, A_, 4'b0011, 2'd1, 13'h0FFF, 4'b0011},
        '{1'b1, O_RD,  2'd3, 1'b0, 13'h0000, 11'h000, E_, 4'b1111, 2'd0, 13'h0000, 4'b0011},
        '{1'b1, O_PRE, 2'd3, 1'b1, 13'h0000, 11'h000, A_, 4'b0010, 2'd3, 13'h0400, 4'b0000},
        '{1'b1, O_REF, 2'd0, 1'b0, 13'h0000, 11'h000, S_, 4'b1111, 2'd0, 13'h0000, 4'b0000},
        '{1'b0, O_ACT, 2'd0, 1'b0, 13'h0000, 11'h000, N_, 4'b1111, 2'd0, 13'h0000, 4'b0000},
        '{1'b1, O_REF, 2'd2, 1'b0, 13'h0000, 11'h000, A_, 4'b0001, 2'd0, 13'h0000, 4'b0000},
        '{1'b1, O_RD,  2'd0, 1'b0, 13'h0000, 11'h000, E_, 4'b1111, 2'd0, 13'h0000, 4'b0000},
        '{1'b1, O_ACT, 2'd2, 1'b0, 13'h1FFF, 11'h000, S_, 4'b1111, 2'd0, 13'h0000, 4'b0000},
        '{1'b0, O_ACT, 2'd0, 1'b0, 13'h0000, 11'h000, N_, 4'b1111, 2'd0, 13'h0000, 4'b0000},
        '{1'b1, O_ACT, 2'd2, 1'b0, 13'h1FFF, 11'h000, A_, 4'b0011, 2'd2, 13'h1FFF, 4'b0100},
        '{1'b1, O_MRS, 2'd0, 1'b0, 13'h0000, 11'h000, E_, 4'b1111, 2'd0, 13'h0000, 4'b0100},
        '{1'b1, O_WR,  2'd2, 1'b0, 13'h0000, 11'h3FF, A_, 4'b0100, 2'd2, 13'h03FF, 4'b0100},
        '{1'b1, O_PRE, 2'd2, 1'b0, 13'h0000, 11'h000, A_, 4'b0010, 2'd2, 13'h0000, 4'b0000}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_flag;
    logic [2:0]  req_op;
    logic [1:0]  req_bank;
    logic [12:0] req_row;
    logic [10:0] req_col;
    logic        req_accept, req_stall, req_error;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;
    logic [3:0]  bank_open;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    sdram_cmd_tracker #(
        .T_RCD (TB_RCD), .T_RP (TB_RP), .BURST_LEN (TB_BL),
        .T_RFC (TB_RFC), .T_MRD (TB_MRD)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_op (req_op),
        .req_bank (req_bank), .req_flag (req_flag), .req_row (req_row),
        .req_col (req_col), .req_accept (req_accept), .req_stall (req_stall),
        .req_error (req_error), .sd_cs_n (sd_cs_n), .sd_ras_n (sd_ras_n),
        .sd_cas_n (sd_cas_n), .sd_we_n (sd_we_n), .sd_ba (sd_ba),
        .sd_addr (sd_addr), .bank_open (bank_open)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] resp_code();
        if (req_accept) return A_;
        if (req_stall)  return S_;
        if (req_error)  return E_;
        return N_;
    endfunction

    function automatic string tag_of(int i);
        case (i)
            0, 19:              return "R1";
            2, 4, 23, 25:       return "R2";
            5, 9, 15:           return "R3";
            3, 7:               return "R4";
            8, 10, 13, 14:      return "R5";
            11, 16, 26:         return "R6";
            1, 12, 17, 21, 24:  return "R7";
            18, 22:             return "R8";
            20:                 return "R9";
            default:            return "R11";
        endcase
    endfunction

    task automatic drive(input logic v, input logic [2:0] op, input logic [1:0] bk,
                         input logic fl, input logic [12:0] row, input logic [10:0] col);
        req_valid = v; req_op = op; req_bank = bk;
        req_flag = fl; req_row = row; req_col = col;
    endtask

    initial begin
        rst_n = 1'b0;
        drive(1'b0, 3'd0, 2'd0, 1'b0, 13'd0, 11'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #5;
        // R10: reset state seen at the ports
        chk("R10", "pins after reset", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b1111);
        chk("R10", "bank_open after reset", bank_open, 4'b0000);
        chk("R8", "answer with no request", resp_code(), N_);

        // Table walk: one request per cycle
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i].v, VEC[i].op, VEC[i].bk, VEC[i].fl, VEC[i].row, VEC[i].col);
            #5;
            chk(tag_of(i), $sformatf("answer step %0d", i), resp_code(), VEC[i].rsp);
            @(posedge clk);
            #1;
            chk(tag_of(i), $sformatf("pins step %0d", i),
                {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, VEC[i].cmd);
            if (VEC[i].rsp == A_) begin
                chk(tag_of(i), $sformatf("bank pins step %0d", i), sd_ba, VEC[i].ba);
                chk(tag_of(i), $sformatf("address step %0d", i), sd_addr, VEC[i].addr);
            end
            chk("R11", $sformatf("bank_open step %0d", i), bank_open, VEC[i].opn);
        end

        // R1: unused op code is an error and issues nothing
        @(negedge clk);
        drive(1'b1, 3'd6, 2'd0, 1'b0, 13'd0, 11'd0);
        #5;
        chk("R1", "op 6 answer", resp_code(), E_);
        @(posedge clk);
        #1;
        chk("R1", "op 6 pins", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b1111);

        // R10: reset while a bank is open and its delay is running
        @(negedge clk);
        drive(1'b1, O_ACT, 2'd3, 1'b0, 13'h0AAA, 11'd0);
        #5;
        chk("R11", "activate bank 3 answer", resp_code(), A_);
        @(posedge clk);
        #1;
        chk("R11", "bank 3 open", bank_open, 4'b1000);
        @(negedge clk);
        rst_n = 1'b0;
        drive(1'b0, 3'd0, 2'd0, 1'b0, 13'd0, 11'd0);
        @(posedge clk);
        #1;
        chk("R10", "bank_open cleared by reset", bank_open, 4'b0000);
        chk("R10", "pins after mid-run reset", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b1111);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, O_ACT, 2'd3, 1'b0, 13'h0555, 11'd0);
        #5;
        chk("R10", "activate right after reset", resp_code(), A_);
        @(posedge clk);
        #1;
        chk("R10", "activate pins after reset", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0011);
        chk("R10", "activate row after reset", sd_addr, 13'h0555);

        @(negedge clk);
        drive(1'b0, 3'd0, 2'd0, 1'b0, 13'd0, 11'd0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule